// File: doc/BRIEF.md
# Indexed Register Slave on SMBus

This block is a two-wire bus target that holds a 32-byte configuration file. Every access names a starting register. A write transaction gives the bus write address, a start offset, a byte count and then that many data bytes, which land in consecutive registers. A read transaction sets the offset with a write address and offset byte, then a repeated START with the read address. The target sends a count byte first, then that many register bytes from consecutive offsets. A single-byte write is a block write with a count of one. A single-byte read is a block read that the master ends with a not-acknowledge after the first data byte.

The register file resets to fixed values. Some bits are read-only: an identity byte, reserved bits, and three strap bits. The strap bits follow an input pin while the power-good input is low and keep that value once power-good is high. The bus data pin is open-drain. The block takes the sensed line level and returns a drive-low enable. It runs on a fast system clock and oversamples both bus wires.

Top module: `smb_idx_regslave`

## Requirements
- R1: The target acknowledges address byte D2h (write) and D3h (read). It does not acknowledge any other address, and it ignores the rest of that transaction until the next START.
- R2: In a block write, the target acknowledges the offset, the count N and N data bytes. The data bytes go to offsets start, start+1 and onward, and each one shows on `cfg_q_o` (byte k at bits 8k+7..8k). The target does not acknowledge or store any byte after the N-th.
- R3: The target does not acknowledge a write count of 00h. Such a transaction changes no register.
- R4: The target does not acknowledge a start offset of 32 or more. A block write that runs past offset 31 gets no acknowledge for the extra bytes and stores none of them.
- R5: A block read returns a count byte and then that many bytes from consecutive offsets. The read offset wraps from 31 to 0. The count is the N of the last accepted block write; after reset it is 8.
- R6: A master not-acknowledge ends a read early. The target releases SDA before the STOP, and the next transaction works normally.
- R7: A single-byte write (count 01h) and a single-byte read (count byte 01h, then one data byte) give a round trip to any register.
- R8: Reset values: byte 0 = FFh, byte 2 = F1h, byte 7 = 05h, byte 17 = 0Fh. Bits 2..0 of byte 6 hold the latched strap. Every other bit is 0.
- R9: Writes have no effect on these bits: all of byte 7 (vendor code 5h in bits 3..0, revision in bits 7..4), bits 2..0 of byte 6, and the reserved bits 3..1 of byte 2, which read 0.
- R10: Byte 6 bits 2..0 track `strap_i` while `pwr_good_i` is low. They hold that value while `pwr_good_i` is high.
- R11: Bytes move MSB first and are sampled on the SCL rising edge. The target changes its SDA drive only while SCL is low. SDA falling with SCL high is a START; SDA rising with SCL high is a STOP. A STOP releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| sda_o | output | 1 | SDA output value, always 0 (open drain) |
| sda_oe_o | output | 1 | When 1, the target pulls SDA low |
| pwr_good_i | input | 1 | Power-good level; low lets the strap bits follow their pin |
| strap_i | input | 3 | Strap pins captured into byte 6 |
| cfg_q_o | output | 256 | All register bytes, byte k at bits 8k+7..8k |

## Verification
Wrong internal state shows up on the bus within one byte frame. A wrong frame counter or pointer puts the acknowledge on the wrong clock. It can also return data from a neighbouring register or keep acknowledging past the count, and a master sees any of these at the ninth clock of the byte involved. A bad write mask or bad reset value shows on `cfg_q_o` one clock after the write strobe, and on the next read-back. A stale read length shows in the count byte, which is the first byte the target sends.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;

  typedef enum logic [2:0] {
    FR_IDLE, FR_ADDR, FR_OFFS, FR_WCNT, FR_WDATA, FR_RCNT, FR_RDATA, FR_WAIT
  } frame_e;

  localparam logic [7:0] WR_ADDR   = 8'hD2;
  localparam logic [7:0] RD_ADDR   = 8'hD3;
  localparam int unsigned OE_A_IDX  = 0;
  localparam int unsigned OE_B_IDX  = 2;
  localparam int unsigned STRAP_IDX = 6;
  localparam int unsigned ID_IDX    = 7;
  localparam int unsigned NMUL_IDX  = 17;
  localparam logic [3:0] VENDOR_CODE = 4'h5;

  // bits software may change in each byte
  function automatic logic [7:0] wr_mask(input int unsigned idx);
    case (idx)
      OE_B_IDX:  wr_mask = 8'hF1;
      STRAP_IDX: wr_mask = 8'hF8;
      ID_IDX:    wr_mask = 8'h00;
      default:   wr_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int unsigned idx, input logic [3:0] rev);
    case (idx)
      OE_A_IDX: rst_val = 8'hFF;
      OE_B_IDX: rst_val = 8'hF1;
      ID_IDX:   rst_val = {rev, VENDOR_CODE};
      NMUL_IDX: rst_val = 8'h0F;
      default:  rst_val = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_idx_bus_if.sv
module smb_idx_bus_if #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_N-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_N-2:0], sda_i};
      scl_d  <= scl_sh[SYNC_N-1];
      sda_d  <= sda_sh[SYNC_N-1];
    end
  end

  assign scl_s     = scl_sh[SYNC_N-1];
  assign sda_s     = sda_sh[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & ~sda_s & sda_d;
  assign stop_det  = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/smb_idx_regfile.sv
module smb_idx_regfile
  import smb_idx_pkg::*;
#(
  parameter int         REG_COUNT = 32,
  parameter int         STRAP_W   = 3,
  parameter logic [3:0] REV_ID    = 4'h0,
  localparam int        IDX_W     = $clog2(REG_COUNT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [7:0]             wr_data,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [7:0]             rd_data,
  input  logic                   pwr_good,
  input  logic [STRAP_W-1:0]     strap,
  output logic [REG_COUNT*8-1:0] cfg_q
);
  logic [STRAP_W-1:0] strap_q;
  logic [7:0]         bytes [REG_COUNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         strap_q <= '0;
    else if (!pwr_good) strap_q <= strap;
  end

  for (genvar k = 0; k < REG_COUNT; k++) begin : g_byte
    localparam logic [7:0] MASK = wr_mask(k);
    localparam logic [7:0] RSTV = rst_val(k, REV_ID);
    logic [7:0] q;

    if (MASK == 8'h00) begin : g_ro
      assign q = RSTV;
    end else begin : g_rw
      logic [7:0] d;
      always_comb begin
        d = q;
        if (wr_en && (wr_idx == IDX_W'(k))) d = (q & ~MASK) | (wr_data & MASK);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RSTV;
        else        q <= d;
      end
    end

    if (k == STRAP_IDX) begin : g_strap
      assign bytes[k] = q | {{(8-STRAP_W){1'b0}}, strap_q};
    end else begin : g_plain
      assign bytes[k] = q;
    end
    assign cfg_q[k*8 +: 8] = bytes[k];
  end

  assign rd_data = bytes[rd_idx];
endmodule

// File: rtl/smb_idx_engine.sv
module smb_idx_engine
  import smb_idx_pkg::*;
#(
  parameter int         REG_COUNT  = 32,
  parameter logic [7:0] RD_LEN_RST = 8'd8,
  localparam int        IDX_W      = $clog2(REG_COUNT),
  localparam logic [7:0] N8        = 8'(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe,
  output logic             bus_idle
);
  frame_e     st, st_n, go, go_n;
  logic [3:0] bitcnt, bitcnt_n;
  logic [6:0] rx_sh, rx_sh_n;
  logic [7:0] tx_sh, tx_sh_n;
  logic [7:0] ptr, ptr_n, rem, rem_n, rd_len, rd_len_n;
  logic       ack_go, ack_go_n, mack, mack_n, oe, oe_n;
  logic [7:0] byte_in;
  logic       rx_frame;

  assign byte_in  = {rx_sh, sda_s};
  assign rd_idx   = (ptr >= N8) ? '0 : ptr[IDX_W-1:0];
  assign wr_idx   = ptr[IDX_W-1:0];
  assign wr_data  = byte_in;
  assign sda_oe   = oe;
  assign bus_idle = (st == FR_IDLE);
  assign rx_frame = (st == FR_ADDR) || (st == FR_OFFS) || (st == FR_WCNT) || (st == FR_WDATA);

  always_comb begin
    st_n = st; go_n = go; bitcnt_n = bitcnt; rx_sh_n = rx_sh; tx_sh_n = tx_sh;
    ptr_n = ptr; rem_n = rem; rd_len_n = rd_len; ack_go_n = ack_go; mack_n = mack;
    oe_n = oe; wr_en = 1'b0;
    if (stop_det) begin
      st_n = FR_IDLE; bitcnt_n = '0; oe_n = 1'b0;
    end else if (start_det) begin
      st_n = FR_ADDR; bitcnt_n = '0; oe_n = 1'b0;
    end else if (st != FR_IDLE && st != FR_WAIT) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          rx_sh_n  = byte_in[6:0];
          bitcnt_n = bitcnt + 4'd1;
          if (bitcnt == 4'd7 && rx_frame) begin
            ack_go_n = 1'b0;
            go_n     = FR_WAIT;
            case (st)
              FR_ADDR: begin
                if (byte_in == WR_ADDR)      begin ack_go_n = 1'b1; go_n = FR_OFFS; end
                else if (byte_in == RD_ADDR) begin ack_go_n = 1'b1; go_n = FR_RCNT; end
              end
              FR_OFFS: if (byte_in < N8) begin
                ack_go_n = 1'b1; ptr_n = byte_in; go_n = FR_WCNT;
              end
              FR_WCNT: if (byte_in != 8'd0) begin
                ack_go_n = 1'b1; rem_n = byte_in; rd_len_n = byte_in; go_n = FR_WDATA;
              end
              FR_WDATA: if (ptr < N8 && rem != 8'd0) begin
                ack_go_n = 1'b1; wr_en = 1'b1;
                ptr_n = ptr + 8'd1; rem_n = rem - 8'd1;
                go_n  = (rem == 8'd1) ? FR_WAIT : FR_WDATA;
              end
              default: ;
            endcase
          end
        end else if (bitcnt == 4'd8) begin
          bitcnt_n = 4'd9;
          mack_n   = ~sda_s;
        end
      end else if (scl_fall) begin
        if (rx_frame) begin
          if (bitcnt == 4'd8) begin
            oe_n = ack_go;
          end else if (bitcnt == 4'd9) begin
            bitcnt_n = '0;
            st_n     = go;
            oe_n     = 1'b0;
            if (go == FR_RCNT) begin
              oe_n    = ~rd_len[7];
              tx_sh_n = {rd_len[6:0], 1'b0};
            end
          end
        end else begin
          if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
            oe_n    = ~tx_sh[7];
            tx_sh_n = {tx_sh[6:0], 1'b0};
          end else if (bitcnt == 4'd8) begin
            oe_n = 1'b0;
          end else if (bitcnt == 4'd9) begin
            bitcnt_n = '0;
            if (!mack || (st == FR_RDATA && rem == 8'd0)) begin
              st_n = FR_WAIT; oe_n = 1'b0;
            end else begin
              st_n    = FR_RDATA;
              oe_n    = ~rd_data[7];
              tx_sh_n = {rd_data[6:0], 1'b0};
              ptr_n   = (rd_idx == IDX_W'(REG_COUNT-1)) ? 8'd0 : 8'(rd_idx) + 8'd1;
              rem_n   = (st == FR_RCNT) ? rd_len - 8'd1 : rem - 8'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FR_IDLE; go <= FR_IDLE; bitcnt <= '0; rx_sh <= '0; tx_sh <= '0;
      ptr <= '0; rem <= '0; rd_len <= RD_LEN_RST; ack_go <= 1'b0; mack <= 1'b0; oe <= 1'b0;
    end else begin
      st <= st_n; go <= go_n; bitcnt <= bitcnt_n; rx_sh <= rx_sh_n; tx_sh <= tx_sh_n;
      ptr <= ptr_n; rem <= rem_n; rd_len <= rd_len_n; ack_go <= ack_go_n; mack <= mack_n; oe <= oe_n;
    end
  end
endmodule

// File: rtl/smb_idx_regslave.sv
module smb_idx_regslave #(
  parameter int         REG_COUNT  = 32,
  parameter int         STRAP_W    = 3,
  parameter int         SYNC_N     = 2,
  parameter logic [3:0] REV_ID     = 4'h0,
  parameter logic [7:0] RD_LEN_RST = 8'd8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_o,
  output logic                   sda_oe_o,
  input  logic                   pwr_good_i,
  input  logic [STRAP_W-1:0]     strap_i,
  output logic [REG_COUNT*8-1:0] cfg_q_o
);
  localparam int IDX_W = $clog2(REG_COUNT);

  logic [1:0]       rst_sync;
  logic             rst_n_s;
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en, in_idle;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];
  assign sda_o   = 1'b0;

  smb_idx_bus_if #(.SYNC_N(SYNC_N)) u_bus (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_idx_engine #(.REG_COUNT(REG_COUNT), .RD_LEN_RST(RD_LEN_RST)) u_engine (
    .clk(clk), .rst_n(rst_n_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe_o), .bus_idle(in_idle)
  );

  smb_idx_regfile #(.REG_COUNT(REG_COUNT), .STRAP_W(STRAP_W), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .pwr_good(pwr_good_i), .strap(strap_i),
    .cfg_q(cfg_q_o)
  );
endmodule

// File: rtl/smb_idx_regslave_chk.sv
module smb_idx_regslave_chk #(
  parameter int REG_COUNT = 32,
  parameter int STRAP_W   = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_s,
  input logic                   start_det,
  input logic                   stop_det,
  input logic                   sda_oe,
  input logic                   in_idle,
  input logic                   wr_en,
  input logic                   pwr_good,
  input logic [REG_COUNT*8-1:0] cfg_q
);
  localparam int ID_LO    = smb_idx_pkg::ID_IDX * 8;
  localparam int STRAP_LO = smb_idx_pkg::STRAP_IDX * 8;

  // R11: drive changes only while SCL is low
  a_r11_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  // R11: a STOP releases the data line
  a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R1: no drive between transactions
  a_r1_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  // R9: the identity byte never changes on a write
  a_r9_id_byte_ro: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(cfg_q[ID_LO +: 8]));

  // R10: strap bits hold once power is good
  a_r10_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && $past(pwr_good)) |-> $stable(cfg_q[STRAP_LO +: STRAP_W]));
endmodule

bind smb_idx_regslave smb_idx_regslave_chk #(.REG_COUNT(REG_COUNT), .STRAP_W(STRAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
  .sda_oe(sda_oe_o), .in_idle(in_idle), .wr_en(wr_en), .pwr_good(pwr_good_i), .cfg_q(cfg_q_o)
);

// File: tb/smb_idx_regslave_bench.sv
module smb_idx_regslave_bench;
  localparam int Q = 6;
  localparam int NV = 8;
  // {offset, write data, expected read-back}
  localparam logic [23:0] VEC [NV] = '{
    {8'd5,  8'hA5, 8'hA5}, {8'd7,  8'h3C, 8'h05}, {8'd6, 8'hFF, 8'hFD},
    {8'd2,  8'h0E, 8'h00}, {8'd2,  8'hF0, 8'hF0}, {8'd17, 8'h96, 8'h96},
    {8'd31, 8'h5A, 8'h5A}, {8'd0,  8'h12, 8'h12}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, pwr_good = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_o, sda_oe;
  logic [255:0] cfg;
  wire  sda_line = sda_m & ~sda_oe;
  int   n_chk = 0, n_fail = 0, n_viol = 0;
  bit   done = 1'b0;
  logic scl_p = 1'b1, oe_p = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #4 clk = ~clk;

  smb_idx_regslave u_smb_idx_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_o(sda_o),
    .sda_oe_o(sda_oe), .pwr_good_i(pwr_good), .strap_i(strap), .cfg_q_o(cfg)
  );

  // R11 monitor: target drive may not move while SCL is high
  always @(posedge clk) begin
    if (rst_n && scl && scl_p && (sda_oe !== oe_p)) n_viol++;
    scl_p <= scl; oe_p <= sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
  endtask
  task automatic recv_byte(input logic nack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl = 1'b0; wq();
    end
    sda_m = nack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  // write wbuf[0..nsend-1] with count cnt, ack bits: [0]=addr [1]=offs [2]=cnt [3+i]=data i
  task automatic blk_write(input logic [7:0] offs, input logic [7:0] cnt, input int nsend,
                           output logic [15:0] acks);
    logic a;
    acks = '0;
    bus_start();
    send_byte(8'hD2, a); acks[0] = a;
    send_byte(offs, a);  acks[1] = a;
    send_byte(cnt, a);   acks[2] = a;
    for (int i = 0; i < nsend; i++) begin send_byte(wbuf[i], a); acks[3+i] = a; end
    bus_stop();
  endtask

  task automatic blk_read(input logic [7:0] offs, input int nread, output logic [7:0] cnt,
                          output logic oe_after);
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(offs, a);
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b0, cnt);
    for (int i = 0; i < nread; i++) recv_byte(i == nread - 1, rbuf[i]);
    oe_after = sda_oe;
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] acks;
    logic [7:0]  cnt;
    logic        oe_a, a;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    pwr_good = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R8 idle drive", {7'd0, sda_oe}, 8'h00);
    chk("R8 byte17 reset", cfg[17*8 +: 8], 8'h0F);
    blk_read(8'd0, 8, cnt, oe_a);
    chk("R5 reset read length", cnt, 8'h08);
    chk("R8 byte0", rbuf[0], 8'hFF);
    chk("R8 byte1", rbuf[1], 8'h00);
    chk("R8 byte2", rbuf[2], 8'hF1);
    chk("R8 byte5", rbuf[5], 8'h00);
    chk("R10 strap latched", rbuf[6], 8'h05);
    chk("R8 byte7 id", rbuf[7], 8'h05);

    // single-byte vectors
    for (int v = 0; v < NV; v++) begin
      wbuf[0] = VEC[v][15:8];
      blk_write(VEC[v][23:16], 8'h01, 1, acks);
      chk("R7 byte write acks", {4'd0, acks[3:0]}, 8'h0F);
      blk_read(VEC[v][23:16], 1, cnt, oe_a);
      chk("R7 byte read count", cnt, 8'h01);
      chk("R9 byte read data", rbuf[0], VEC[v][7:0]);
      chk("R6 released after nack", {7'd0, oe_a}, 8'h00);
    end

    // block write of 4 with a surplus fifth byte
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44; wbuf[4] = 8'h55;
    blk_write(8'd8, 8'd4, 5, acks);
    chk("R2 block acks", acks[7:0], 8'h7F);
    chk("R2 cfg byte8", cfg[8*8 +: 8], 8'h11);
    chk("R2 cfg byte11", cfg[11*8 +: 8], 8'h44);
    chk("R2 surplus not stored", cfg[12*8 +: 8], 8'h00);
    blk_read(8'd8, 4, cnt, oe_a);
    chk("R5 count from write", cnt, 8'h04);
    chk("R5 data0", rbuf[0], 8'h11);
    chk("R5 data3", rbuf[3], 8'h44);

    // early end of a block read
    blk_read(8'd8, 2, cnt, oe_a);
    chk("R6 early data", rbuf[1], 8'h22);
    chk("R6 early release", {7'd0, oe_a}, 8'h00);

    // run past the last register, then wrapped read
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    blk_write(8'd30, 8'd3, 3, acks);
    chk("R4 past end acks", acks[7:0], 8'h1F);
    blk_read(8'd30, 3, cnt, oe_a);
    chk("R4 byte31", rbuf[1], 8'hBB);
    chk("R5 wrap to 0", rbuf[2], 8'h12);

    // offset out of range
    bus_start(); send_byte(8'hD2, a); send_byte(8'd40, a); bus_stop();
    chk("R4 offset 40 nack", {7'd0, a}, 8'h00);

    // zero count
    bus_start(); send_byte(8'hD2, a); send_byte(8'd5, a); send_byte(8'd0, a);
    chk("R3 zero count nack", {7'd0, a}, 8'h00);
    send_byte(8'h77, a); bus_stop();
    chk("R3 data after zero count", {7'd0, a}, 8'h00);
    blk_read(8'd5, 3, cnt, oe_a);
    chk("R3 count kept", cnt, 8'h03);
    chk("R3 byte5 unchanged", rbuf[0], 8'hA5);

    // foreign address
    bus_start(); send_byte(8'hA0, a);
    chk("R1 foreign address nack", {7'd0, a}, 8'h00);
    send_byte(8'h05, a); bus_stop();
    chk("R1 rest ignored", {7'd0, a}, 8'h00);

    // strap pin moves after power-good
    strap = 3'b010;
    repeat (20) @(negedge clk);
    blk_read(8'd6, 3, cnt, oe_a);
    chk("R10 strap held", rbuf[0], 8'hFD);
    chk("R9 id after writes", rbuf[1], 8'h05);

    chk("R11 drive moved with SCL high", n_viol[7:0], 8'h00);
    chk("R11 idle after stop", {7'd0, sda_oe}, 8'h00);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule